// File: doc/BRIEF.md
# Pad Function Select Multiplexer

This block sits between a bank of general-purpose pads and the on-chip functions that can use them. Every pad offers six digital functions. A 3-bit select field per pad chooses one of them. The chosen function's output value and output enable reach the pad. The pad's input value is fanned out to all six function inputs of that pad. Each function input has a fixed policy that sets what it reads when its function is not the one selected: it may follow the pad, tie to 1 or tie to 0.

The block also stores a per-pad input enable, pull-up, pull-down and a 2-bit drive strength. All of these are loaded through a synchronous write port that carries a pad index. Some pads are built as input-only. For those pads the block never drives an output and never turns on a pull, whatever the configuration says.

A two-state bring-up controller governs reset:
- `ST_HOLD` is entered asynchronously when reset asserts. In this state every output enable is off, the pads show their reset input-enable and pull values, and no function counts as selected.
- The transition `HOLD_TO_RUN` fires on the first clock edge after reset is released.
- In `ST_RUN` the stored configuration drives the pads. The select field resets to 0, so function 1 is in control from then on.

Top module: `padmux_top`

## Requirements
- R1: In ST_RUN, a select value k from 0 to 5 on pad p drives pad_out[p] from fn_out[p*6+k] and pad_oe[p] from fn_oe[p*6+k] (function number k+1), unless the pad is input-only.
- R2: A select value of 6 or 7 selects no function. pad_out and pad_oe of that pad are 0, and every function input of the pad reads its unselected value.
- R3: A function input whose 2-bit policy code is 0 (pass) or 3 (pass) always reads pad_in[p] AND pad_ie[p], whether or not its function is selected. The policy of function f on pad p sits at bits [2*(p*6+f) +: 2] of POLICY.
- R4: A function input with policy code 1 reads constant 1 while its function is not selected. While selected, it reads pad_in[p] AND pad_ie[p].
- R5: A function input with policy code 2 reads constant 0 while its function is not selected. While selected, it reads pad_in[p] AND pad_ie[p].
- R6: While reset is asserted, and in the ST_HOLD cycle after reset is released, pad_oe and pad_out are 0, no function is selected, and pad_ie, pad_pu and pad_pd take the per-pad reset values RST_IE, RST_PU and RST_PD.
- R7: After the HOLD_TO_RUN edge with no writes, every pad that is not input-only is controlled by function 1: pad_oe[p] equals fn_oe[p*6].
- R8: For a pad marked in INPUT_ONLY, pad_oe, pad_out, pad_pu and pad_pd are always 0.
- R9: pad_pu and pad_pd are never 1 together. When both pulls are configured, only the pull-up is asserted.
- R10: When cfg_we is 1 at a clock edge and cfg_pad is below NUM_PADS, that pad's select, input enable, pull-up, pull-down and drive strength take cfg_sel, cfg_ie, cfg_pu, cfg_pd and cfg_drv. The new values show after that edge. A cfg_pad of NUM_PADS or above changes nothing.
- R11: pad_drv[2p+1:2p] always shows the stored drive strength of pad p. Its reset value comes from RST_DRV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_pad | input | PAD_W | Pad index of the write |
| cfg_sel | input | 3 | Function select written (N-1 selects function N) |
| cfg_ie | input | 1 | Input enable written |
| cfg_pu | input | 1 | Pull-up written |
| cfg_pd | input | 1 | Pull-down written |
| cfg_drv | input | 2 | Drive strength written |
| fn_out | input | NUM_PADS*6 | Output value of each function, index p*6+f |
| fn_oe | input | NUM_PADS*6 | Output enable of each function, index p*6+f |
| fn_in | output | NUM_PADS*6 | Input value seen by each function, index p*6+f |
| pad_in | input | NUM_PADS | Value received from each pad |
| pad_out | output | NUM_PADS | Value driven to each pad |
| pad_oe | output | NUM_PADS | Output enable of each pad |
| pad_ie | output | NUM_PADS | Input enable of each pad |
| pad_pu | output | NUM_PADS | Pull-up enable of each pad |
| pad_pd | output | NUM_PADS | Pull-down enable of each pad |
| pad_drv | output | 2*NUM_PADS | Drive strength of each pad |

## Verification
The assertions assume that the function outputs, function enables, pad inputs and write port are stable around the sampling edge. They also assume that reset is applied before any check can matter. The properties on function inputs are combinational relations between pad_in, pad_ie and fn_in, so they hold whatever values arrive. The bench changes every input only at the falling clock edge. It draws select values over the full 3-bit range and pad indices above the bank size. It writes with both pulls set and writes to the input-only pad. It also releases reset just after a rising edge, so that the ST_HOLD cycle is visible at the ports.

// File: rtl/padmux_pkg.sv
package padmux_pkg;

    localparam int FUNC_PER_PAD = 6;
    localparam int SEL_W        = 3;
    localparam int DRV_W        = 2;

    typedef enum logic [1:0] {
        POL_PASS     = 2'd0,
        POL_TIE1     = 2'd1,
        POL_TIE0     = 2'd2,
        POL_PASS_ALT = 2'd3
    } in_policy_e;

    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } bringup_state_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             ie;
        logic             pu;
        logic             pd;
        logic [DRV_W-1:0] drv;
    } pad_cfg_t;

    function automatic logic idle_input(input logic [1:0] pol, input logic pin);
        logic v;
        case (pol)
            POL_TIE1: v = 1'b1;
            POL_TIE0: v = 1'b0;
            default:  v = pin;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/padmux_ctrl.sv
module padmux_ctrl
    import padmux_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic run_en
);

    bringup_state_e state_q;
    bringup_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_HOLD;
        endcase
    end

    always_comb begin
        run_en = 1'b0;
        unique case (state_q)
            ST_HOLD: run_en = 1'b0;
            ST_RUN:  run_en = 1'b1;
            default: run_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/padmux_cfg_regs.sv
module padmux_cfg_regs
    import padmux_pkg::*;
#(
    parameter int                        NUM_PADS = 5,
    parameter int                        PAD_W    = 3,
    parameter logic [NUM_PADS-1:0]       RST_IE   = '1,
    parameter logic [NUM_PADS-1:0]       RST_PU   = '0,
    parameter logic [NUM_PADS-1:0]       RST_PD   = '0,
    parameter logic [DRV_W*NUM_PADS-1:0] RST_DRV  = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [PAD_W-1:0]             wr_pad,
    input  pad_cfg_t                     wr_data,
    output pad_cfg_t [NUM_PADS-1:0]      cfg_q
);

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        pad_cfg_t reg_q;
        logic     hit;

        assign hit = wr_en && (wr_pad == PAD_W'(p));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                reg_q.sel <= '0;
                reg_q.ie  <= RST_IE[p];
                reg_q.pu  <= RST_PU[p];
                reg_q.pd  <= RST_PD[p];
                reg_q.drv <= RST_DRV[DRV_W*p +: DRV_W];
            end else if (hit) begin
                reg_q <= wr_data;
            end
        end

        assign cfg_q[p] = reg_q;
    end

endmodule

// File: rtl/padmux_pad_slice.sv
module padmux_pad_slice
    import padmux_pkg::*;
#(
    parameter logic                        IN_ONLY = 1'b0,
    parameter logic                        RST_IE  = 1'b1,
    parameter logic                        RST_PU  = 1'b0,
    parameter logic                        RST_PD  = 1'b0,
    parameter logic [2*FUNC_PER_PAD-1:0]   POLICY  = '0
) (
    input  logic                    run_en,
    input  pad_cfg_t                cfg,
    input  logic [FUNC_PER_PAD-1:0] fn_out,
    input  logic [FUNC_PER_PAD-1:0] fn_oe,
    output logic [FUNC_PER_PAD-1:0] fn_in,
    input  logic                    pad_in,
    output logic                    pad_out,
    output logic                    pad_oe,
    output logic                    pad_ie,
    output logic                    pad_pu,
    output logic                    pad_pd,
    output logic [DRV_W-1:0]        pad_drv
);

    logic [FUNC_PER_PAD-1:0] sel_hit;
    logic                    pin;
    logic                    pu_raw;
    logic                    pd_raw;

    for (genvar f = 0; f < FUNC_PER_PAD; f++) begin : g_fn
        assign sel_hit[f] = run_en && (cfg.sel == SEL_W'(f));
        assign fn_in[f]   = sel_hit[f] ? pin
                                       : idle_input(POLICY[2*f +: 2], pin);
    end

    assign pad_ie = run_en ? cfg.ie : RST_IE;
    assign pin    = pad_in & pad_ie;
    assign pu_raw = run_en ? cfg.pu : RST_PU;
    assign pd_raw = run_en ? cfg.pd : RST_PD;

    if (IN_ONLY) begin : g_in_only
        assign pad_out = 1'b0;
        assign pad_oe  = 1'b0;
        assign pad_pu  = 1'b0;
        assign pad_pd  = 1'b0;
    end else begin : g_bidir
        assign pad_out = |(sel_hit & fn_out);
        assign pad_oe  = |(sel_hit & fn_oe);
        assign pad_pu  = pu_raw;
        assign pad_pd  = pd_raw & ~pu_raw;
    end

    assign pad_drv = cfg.drv;

endmodule

// File: rtl/padmux_top.sv
module padmux_top
    import padmux_pkg::*;
#(
    parameter int                                    NUM_PADS   = 5,
    parameter logic [NUM_PADS-1:0]                   INPUT_ONLY = 5'b10000,
    parameter logic [NUM_PADS-1:0]                   RST_IE     = 5'b10111,
    parameter logic [NUM_PADS-1:0]                   RST_PU     = 5'b00110,
    parameter logic [NUM_PADS-1:0]                   RST_PD     = 5'b11100,
    parameter logic [DRV_W*NUM_PADS-1:0]             RST_DRV    = {NUM_PADS{2'b10}},
    parameter logic [2*FUNC_PER_PAD*NUM_PADS-1:0]    POLICY     = {NUM_PADS{12'h9E4}},
    localparam int                                   PAD_W      = (NUM_PADS > 1) ? $clog2(NUM_PADS + 1) : 1,
    localparam int                                   NF         = NUM_PADS * FUNC_PER_PAD
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [PAD_W-1:0]          cfg_pad,
    input  logic [SEL_W-1:0]          cfg_sel,
    input  logic                      cfg_ie,
    input  logic                      cfg_pu,
    input  logic                      cfg_pd,
    input  logic [DRV_W-1:0]          cfg_drv,
    input  logic [NF-1:0]             fn_out,
    input  logic [NF-1:0]             fn_oe,
    output logic [NF-1:0]             fn_in,
    input  logic [NUM_PADS-1:0]       pad_in,
    output logic [NUM_PADS-1:0]       pad_out,
    output logic [NUM_PADS-1:0]       pad_oe,
    output logic [NUM_PADS-1:0]       pad_ie,
    output logic [NUM_PADS-1:0]       pad_pu,
    output logic [NUM_PADS-1:0]       pad_pd,
    output logic [DRV_W*NUM_PADS-1:0] pad_drv
);

    logic                    run_en;
    pad_cfg_t                wr_data;
    pad_cfg_t [NUM_PADS-1:0] cfg_q;

    assign wr_data = '{sel: cfg_sel, ie: cfg_ie, pu: cfg_pu, pd: cfg_pd, drv: cfg_drv};

    padmux_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (run_en)
    );

    padmux_cfg_regs #(
        .NUM_PADS (NUM_PADS),
        .PAD_W    (PAD_W),
        .RST_IE   (RST_IE),
        .RST_PU   (RST_PU),
        .RST_PD   (RST_PD),
        .RST_DRV  (RST_DRV)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_pad  (cfg_pad),
        .wr_data (wr_data),
        .cfg_q   (cfg_q)
    );

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_slice
        padmux_pad_slice #(
            .IN_ONLY (INPUT_ONLY[p]),
            .RST_IE  (RST_IE[p]),
            .RST_PU  (RST_PU[p]),
            .RST_PD  (RST_PD[p]),
            .POLICY  (POLICY[2*FUNC_PER_PAD*p +: 2*FUNC_PER_PAD])
        ) u_slice (
            .run_en  (run_en),
            .cfg     (cfg_q[p]),
            .fn_out  (fn_out[FUNC_PER_PAD*p +: FUNC_PER_PAD]),
            .fn_oe   (fn_oe[FUNC_PER_PAD*p +: FUNC_PER_PAD]),
            .fn_in   (fn_in[FUNC_PER_PAD*p +: FUNC_PER_PAD]),
            .pad_in  (pad_in[p]),
            .pad_out (pad_out[p]),
            .pad_oe  (pad_oe[p]),
            .pad_ie  (pad_ie[p]),
            .pad_pu  (pad_pu[p]),
            .pad_pd  (pad_pd[p]),
            .pad_drv (pad_drv[DRV_W*p +: DRV_W])
        );
    end

endmodule

// File: rtl/padmux_checker.sv
module padmux_checker
    import padmux_pkg::*;
#(
    parameter int                                 NUM_PADS   = 5,
    parameter logic [NUM_PADS-1:0]                INPUT_ONLY = '0,
    parameter logic [2*FUNC_PER_PAD*NUM_PADS-1:0] POLICY     = '0,
    parameter int                                 PAD_W      = 3,
    parameter int                                 NF         = NUM_PADS * FUNC_PER_PAD
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_we,
    input logic [PAD_W-1:0]          cfg_pad,
    input logic [DRV_W-1:0]          cfg_drv,
    input logic [NF-1:0]             fn_out,
    input logic [NF-1:0]             fn_oe,
    input logic [NF-1:0]             fn_in,
    input logic [NUM_PADS-1:0]       pad_in,
    input logic [NUM_PADS-1:0]       pad_out,
    input logic [NUM_PADS-1:0]       pad_oe,
    input logic [NUM_PADS-1:0]       pad_ie,
    input logic [NUM_PADS-1:0]       pad_pu,
    input logic [NUM_PADS-1:0]       pad_pd,
    input logic [DRV_W*NUM_PADS-1:0] pad_drv
);

    // R6: nothing is driven while reset is held
    always @(posedge clk) begin
        if (rst_n === 1'b0) begin
            a_r6_quiet_in_reset: assert (pad_oe == '0 && pad_out == '0);
        end
    end

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        a_r9_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            !(pad_pu[p] && pad_pd[p]));

        a_r1_oe_from_function: assert property (@(posedge clk) disable iff (!rst_n)
            pad_oe[p] |-> (fn_oe[FUNC_PER_PAD*p +: FUNC_PER_PAD] != '0));

        a_r10_drv_written: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_pad == PAD_W'(p)) |=> (pad_drv[DRV_W*p +: DRV_W] == $past(cfg_drv)));

        if (INPUT_ONLY[p]) begin : g_inonly
            a_r8_input_only_passive: assert property (@(posedge clk) disable iff (!rst_n)
                !pad_oe[p] && !pad_out[p] && !pad_pu[p] && !pad_pd[p]);
        end

        for (genvar f = 0; f < FUNC_PER_PAD; f++) begin : g_fn
            localparam int          IDX = FUNC_PER_PAD * p + f;
            localparam logic [1:0]  POL = POLICY[2*IDX +: 2];
            if (POL == 2'd1) begin : g_t1
                a_r4_tie1_high: assert property (@(posedge clk) disable iff (!rst_n)
                    (pad_in[p] && pad_ie[p]) |-> fn_in[IDX]);
            end else if (POL == 2'd2) begin : g_t0
                a_r5_tie0_low: assert property (@(posedge clk) disable iff (!rst_n)
                    !(pad_in[p] && pad_ie[p]) |-> !fn_in[IDX]);
            end else begin : g_pass
                a_r3_pass_follows: assert property (@(posedge clk) disable iff (!rst_n)
                    fn_in[IDX] == (pad_in[p] && pad_ie[p]));
            end
        end
    end

endmodule

bind padmux_top padmux_checker #(
    .NUM_PADS   (NUM_PADS),
    .INPUT_ONLY (INPUT_ONLY),
    .POLICY     (POLICY),
    .PAD_W      (PAD_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_pad (cfg_pad),
    .cfg_drv (cfg_drv),
    .fn_out  (fn_out),
    .fn_oe   (fn_oe),
    .fn_in   (fn_in),
    .pad_in  (pad_in),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .pad_ie  (pad_ie),
    .pad_pu  (pad_pu),
    .pad_pd  (pad_pd),
    .pad_drv (pad_drv)
);

// File: tb/tb_padmux_top.sv
module tb_padmux_top;

    localparam int                 CLK_PERIOD = 10;
    localparam int                 NP   = 5;
    localparam int                 FP   = 6;
    localparam int                 NF   = NP * FP;
    localparam int                 PW   = 3;
    localparam logic [NP-1:0]      IN_ONLY = 5'b10000;
    localparam logic [NP-1:0]      R_IE = 5'b10111;
    localparam logic [NP-1:0]      R_PU = 5'b00110;
    localparam logic [NP-1:0]      R_PD = 5'b11100;
    localparam logic [2*NP-1:0]    R_DRV = {NP{2'b10}};
    localparam logic [2*NF-1:0]    POL = {NP{12'h9E4}};

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [PW-1:0] cfg_pad;
    logic [2:0]    cfg_sel;
    logic          cfg_ie, cfg_pu, cfg_pd;
    logic [1:0]    cfg_drv;
    logic [NF-1:0] fn_out, fn_oe, fn_in;
    logic [NP-1:0] pad_in, pad_out, pad_oe, pad_ie, pad_pu, pad_pd;
    logic [2*NP-1:0] pad_drv;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    padmux_top #(
        .NUM_PADS(NP), .INPUT_ONLY(IN_ONLY), .RST_IE(R_IE), .RST_PU(R_PU),
        .RST_PD(R_PD), .RST_DRV(R_DRV), .POLICY(POL)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pad(cfg_pad),
        .cfg_sel(cfg_sel), .cfg_ie(cfg_ie), .cfg_pu(cfg_pu), .cfg_pd(cfg_pd),
        .cfg_drv(cfg_drv), .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_drv(pad_drv)
    );

    // behavioural model of the stored state
    int m_sel [NP];
    int m_ie  [NP];
    int m_pu  [NP];
    int m_pd  [NP];
    int m_drv [NP];
    bit m_run;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 1'b0;
            for (int p = 0; p < NP; p++) begin
                m_sel[p] = 0;
                m_ie[p]  = R_IE[p];
                m_pu[p]  = R_PU[p];
                m_pd[p]  = R_PD[p];
                m_drv[p] = R_DRV[2*p +: 2];
            end
        end else begin
            if (cfg_we && int'(cfg_pad) < NP) begin
                m_sel[cfg_pad] = cfg_sel;
                m_ie[cfg_pad]  = cfg_ie;
                m_pu[cfg_pad]  = cfg_pu;
                m_pd[cfg_pad]  = cfg_pd;
                m_drv[cfg_pad] = cfg_drv;
            end
            m_run = 1'b1;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        for (int p = 0; p < NP; p++) begin
            int    ie_e, pu_e, pd_e, out_e, oe_e, pin, pol, fsel, in_e;
            string tag;
            ie_e = m_run ? m_ie[p] : R_IE[p];
            pu_e = m_run ? m_pu[p] : R_PU[p];
            pd_e = m_run ? m_pd[p] : R_PD[p];
            if (IN_ONLY[p]) begin pu_e = 0; pd_e = 0; end
            if (pu_e != 0) pd_e = 0;
            out_e = 0; oe_e = 0;
            if (m_run && !IN_ONLY[p] && m_sel[p] < FP) begin
                out_e = fn_out[p*FP + m_sel[p]];
                oe_e  = fn_oe[p*FP + m_sel[p]];
            end
            tag = !m_run ? "R6" : IN_ONLY[p] ? "R8" : (m_sel[p] >= FP) ? "R2" : "R1";
            chk(tag, $sformatf("pad%0d oe", p), int'(pad_oe[p]), oe_e);
            chk(tag, $sformatf("pad%0d out", p), int'(pad_out[p]), out_e);
            tag = !m_run ? "R6" : "R10";
            chk(tag, $sformatf("pad%0d ie", p), int'(pad_ie[p]), ie_e);
            tag = IN_ONLY[p] ? "R8" : (!m_run ? "R6" : "R9");
            chk(tag, $sformatf("pad%0d pu", p), int'(pad_pu[p]), pu_e);
            chk(tag, $sformatf("pad%0d pd", p), int'(pad_pd[p]), pd_e);
            chk("R11", $sformatf("pad%0d drv", p), int'(pad_drv[2*p +: 2]), m_drv[p]);
            pin = (pad_in[p] && ie_e != 0) ? 1 : 0;
            for (int f = 0; f < FP; f++) begin
                pol  = int'(POL[2*(p*FP+f) +: 2]);
                fsel = (m_run && m_sel[p] == f) ? 1 : 0;
                if (fsel != 0 || pol == 0 || pol == 3) in_e = pin;
                else if (pol == 1) in_e = 1;
                else in_e = 0;
                tag = (pol == 1) ? "R4" : (pol == 2) ? "R5" : "R3";
                chk(tag, $sformatf("pad%0d fn%0d in", p, f), int'(fn_in[p*FP+f]), in_e);
            end
        end
    endtask

    task automatic drive_random();
        fn_out  = NF'({$urandom, $urandom});
        fn_oe   = NF'({$urandom, $urandom});
        pad_in  = NP'($urandom);
        cfg_we  = ($urandom % 3) == 0;
        cfg_pad = PW'($urandom);
        cfg_sel = 3'($urandom);
        cfg_ie  = 1'($urandom);
        cfg_pu  = 1'($urandom);
        cfg_pd  = 1'($urandom);
        cfg_drv = 2'($urandom);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b1;
        cfg_we = 1'b0; cfg_pad = '0; cfg_sel = '0; cfg_ie = 1'b0;
        cfg_pu = 1'b0; cfg_pd = 1'b0; cfg_drv = '0;
        fn_out = '1; fn_oe = '1; pad_in = '1;
        #1 rst_n = 1'b0;

        // R6: reset state, writes during reset must not land (R10)
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            compare_all();
            drive_random();
        end

        // release just after a rising edge so the HOLD cycle is visible (R6)
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        compare_all();

        // directed: out-of-range pad index writes nothing (R10)
        cfg_we = 1'b1; cfg_pad = PW'(NP); cfg_drv = 2'b01; cfg_sel = 3'd3;
        @(negedge clk);
        compare_all();
        chk("R10", "pad0 drv after stray write", int'(pad_drv[1:0]), int'(R_DRV[1:0]));

        // directed: both pulls on pad 0 (R9), then select 7 (R2)
        cfg_pad = '0; cfg_pu = 1'b1; cfg_pd = 1'b1; cfg_sel = 3'd7; cfg_ie = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R9", "pad0 pd with both set", int'(pad_pd[0]), 0);
        chk("R2", "pad0 oe with select 7", int'(pad_oe[0]), 0);
        compare_all();

        // directed: input-only pad asked to drive (R8)
        cfg_we = 1'b1; cfg_pad = PW'(4); cfg_sel = 3'd0; cfg_pu = 1'b1; cfg_pd = 1'b0;
        fn_oe = '1; fn_out = '1;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R8", "input-only pad4 oe", int'(pad_oe[4]), 0);
        chk("R8", "input-only pad4 pu", int'(pad_pu[4]), 0);
        compare_all();

        // random phase
        for (int c = 0; c < 1500; c++) begin
            drive_random();
            @(negedge clk);
            compare_all();
        end

        // R7: fresh reset, function 1 controls each driving pad
        cfg_we = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        compare_all();
        rst_n = 1'b1;
        fn_oe = '0;
        for (int p = 0; p < NP; p++) fn_oe[p*FP] = 1'b1;
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            chk("R7", $sformatf("pad%0d oe from function 1", p),
                int'(pad_oe[p]), IN_ONLY[p] ? 0 : 1);
        end
        compare_all();
        fn_oe = '1;
        for (int p = 0; p < NP; p++) fn_oe[p*FP] = 1'b0;
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            chk("R7", $sformatf("pad%0d oe ignores other functions", p), int'(pad_oe[p]), 0);
        end
        compare_all();

        finish_run();
    end

endmodule